// File: doc/BRIEF.md
# XNOR Shift-Register Terminal Counter

This block counts with a 10-bit linear feedback shift register in place of a binary adder. Only the terminal event is needed here, or any repeating sequence is acceptable. Each stage takes its new value from the stage beside it, and one XNOR of two stages feeds stage 1. The step costs one gate level whatever the register width, because no carry chain is involved.

A clock enable advances the register. The clock itself is never gated. The state is compared with a terminal pattern supplied on an input. When they match on an enabled cycle, the block raises a one-cycle pulse and the register restarts from zero. The pulse therefore divides the enabled clock by N, where N is one more than the number of steps from zero to the terminal pattern. Finding that pattern for a chosen N is left to the user of the block.

XNOR feedback makes all-zeros a legal state, so the register can start from it. The all-ones pattern is the single lock-up state. The block never produces it, and escapes from it if it ever appears.

Top module: `lfsr_term_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes all zeros.
- R2: With `en` low and a state other than all ones, the state holds its value across a clock edge.
- R3: With `en` high, no terminal match and a state other than all ones, the next state is the old state shifted one place toward the MSB. Bit 0 takes the XNOR of old bit 9 and old bit 6.
- R4: Started from zero with no reachable terminal pattern (`term_val` all ones), the state walks through 1023 distinct values and is zero again after exactly 1023 enabled clocks.
- R5: `term_pulse` is high exactly when `en` is high, the state equals `term_val`, and the state is not all ones. It is combinational within the cycle.
- R6: An enabled clock edge on a terminal match loads all zeros. With `term_val` set to the state reached k steps after zero, the pulse repeats every k+1 enabled clocks. With k = 0, it is high on every enabled cycle.
- R7: The state output never shows all ones. If the register holds all ones, the next clock edge loads zero whatever `en` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable that advances the register |
| term_val | input | 10 | Terminal pattern to match |
| state | output | 10 | Current register contents |
| term_pulse | output | 1 | Terminal-match pulse |

## Verification
The assertions take reset to be applied at the first clock edge. They also take `en` and `term_val` to be stable around each rising edge, so that the match seen in the cycle is the match the register acts on. The bench changes inputs only on falling edges and keeps reset high for several clocks at the start. Since no input can load all ones, the escape from the lock-up state is guarded only by assertion. The bench instead confirms over full sequences that the pattern never appears.

// File: rtl/lfsr_tc_pkg.sv
package lfsr_tc_pkg;

   // Next-state source chosen by the decision logic.
   typedef enum logic [1:0] {
      NS_HOLD = 2'd0,
      NS_ADV  = 2'd1,
      NS_ZERO = 2'd2
   } ns_sel_e;

endpackage

// File: rtl/lfsr_tc_feedback.sv
module lfsr_tc_feedback #(
   parameter int WIDTH  = 10,
   parameter int TAP_HI = 10,
   parameter int TAP_LO = 7
) (
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] adv
);
   localparam int HI_IDX = TAP_HI - 1;
   localparam int LO_IDX = TAP_LO - 1;

   logic fb;

   // XNOR feedback: all ones maps to all ones, so that is the lock-up state.
   assign fb = ~(cur[HI_IDX] ^ cur[LO_IDX]);

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      if (i == 0) begin : g_head
         assign adv[i] = fb;
      end else begin : g_body
         assign adv[i] = cur[i-1];
      end
   end

endmodule

// File: rtl/lfsr_tc_match.sv
module lfsr_tc_match
   import lfsr_tc_pkg::*;
#(
   parameter int WIDTH = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] term_val,
   output logic             hit,
   output ns_sel_e          sel
);
   localparam logic [WIDTH-1:0] LOCK_PAT = {WIDTH{1'b1}};

   logic lock;
   logic eq;

   assign lock = (cur == LOCK_PAT);
   assign eq   = (cur == term_val);
   assign hit  = en & eq & ~lock;

   always_comb begin
      if (lock)      sel = NS_ZERO;
      else if (!en)  sel = NS_HOLD;
      else if (eq)   sel = NS_ZERO;
      else           sel = NS_ADV;
   end

   // R5: a pulse only ever appears on an enabled cycle
   assert_pulse_needs_en_R5: assert property (@(posedge clk) disable iff (rst)
      hit |-> en);

   // R7: the lock-up pattern always selects the zero load
   assert_lock_selects_zero_R7: assert property (@(posedge clk) disable iff (rst)
      (cur == LOCK_PAT) |-> (sel == NS_ZERO));

endmodule

// File: rtl/lfsr_tc_state.sv
module lfsr_tc_state
   import lfsr_tc_pkg::*;
#(
   parameter int WIDTH = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  ns_sel_e          sel,
   input  logic [WIDTH-1:0] adv,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] d;

   always_comb begin
      unique case (sel)
         NS_HOLD: d = q;
         NS_ADV:  d = adv;
         NS_ZERO: d = '0;
         default: d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end

   // R3: an advance takes the feedback network's value
   assert_adv_loaded_R3: assert property (@(posedge clk) disable iff (rst)
      (sel == NS_ADV) |=> (q == $past(adv)));

   // R2: a hold keeps the register unchanged
   assert_hold_stable_R2: assert property (@(posedge clk) disable iff (rst)
      (sel == NS_HOLD) |=> $stable(q));

endmodule

// File: rtl/lfsr_term_counter.sv
module lfsr_term_counter
   import lfsr_tc_pkg::*;
#(
   parameter int WIDTH  = 10,
   parameter int TAP_HI = 10,
   parameter int TAP_LO = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [WIDTH-1:0] term_val,
   output logic [WIDTH-1:0] state,
   output logic             term_pulse
);
   localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

   if (WIDTH < 3) begin : g_chk_w
      $error("lfsr_term_counter: WIDTH must be at least 3");
   end
   if (TAP_HI != WIDTH) begin : g_chk_hi
      $error("lfsr_term_counter: TAP_HI must equal WIDTH");
   end
   if (TAP_LO < 1 || TAP_LO >= TAP_HI) begin : g_chk_lo
      $error("lfsr_term_counter: TAP_LO must lie in 1..TAP_HI-1");
   end

   logic [WIDTH-1:0] adv;
   ns_sel_e          sel;
   logic             hit;

   lfsr_tc_feedback #(.WIDTH(WIDTH), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_fb (
      .cur (state),
      .adv (adv)
   );

   lfsr_tc_match #(.WIDTH(WIDTH)) u_match (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .cur      (state),
      .term_val (term_val),
      .hit      (hit),
      .sel      (sel)
   );

   lfsr_tc_state #(.WIDTH(WIDTH)) u_reg (
      .clk (clk),
      .rst (rst),
      .sel (sel),
      .adv (adv),
      .q   (state)
   );

   assign term_pulse = hit;

   // R6: an enabled match reloads zero
   assert_reload_zero_R6: assert property (@(posedge clk) disable iff (rst)
      (en && state == term_val && state != ONES) |=> (state == '0));

   // R7: escape from the lock-up pattern on the next edge
   assert_lock_escape_R7: assert property (@(posedge clk) disable iff (rst)
      (state == ONES) |=> (state == '0));

   // R5: the pulse coincides with a match of the terminal pattern
   assert_pulse_match_R5: assert property (@(posedge clk) disable iff (rst)
      term_pulse |-> (state == term_val));

   // R2: enable low holds a legal state
   assert_hold_port_R2: assert property (@(posedge clk) disable iff (rst)
      (!en && state != ONES) |=> $stable(state));

endmodule

// File: tb/tb_lfsr_term_counter.sv
`timescale 1ns/1ps
module tb_lfsr_term_counter;
   localparam int W = 10;
   localparam logic [W-1:0] ONES = '1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en = 1'b0;
   logic [W-1:0] term_val = ONES;
   logic [W-1:0] state;
   logic term_pulse;

   int n_chk = 0;
   int n_bad = 0;
   int n_pulse = 0;
   logic [W-1:0] m_state = '0;

   always #2.5 clk = ~clk;

   lfsr_term_counter dut (
      .clk(clk), .rst(rst), .en(en), .term_val(term_val),
      .state(state), .term_pulse(term_pulse)
   );

   function automatic logic [W-1:0] nxt(input logic [W-1:0] s);
      return {s[W-2:0], ~(s[9] ^ s[6])};
   endfunction

   task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One clock: inputs at the falling edge, pulse checked there, state after the rise.
   task automatic step(input logic e, input string req);
      logic exp_p;
      @(negedge clk);
      en = e;
      #1;
      exp_p = e && (m_state == term_val) && (m_state != ONES);
      chk({9'd0, term_pulse}, {9'd0, exp_p}, {req, " pulse"});
      if (term_pulse) n_pulse++;
      @(posedge clk);
      #1;
      if (m_state == ONES) m_state = '0;
      else if (e) m_state = exp_p ? '0 : nxt(m_state);
      chk(state, m_state, {req, " state"});
      if (state == ONES) begin
         n_chk++; n_bad++;
         $display("FAIL R7: actual %h expected not %h", state, ONES);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst = 1'b1; en = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk(state, '0, "R1 reset");
      @(negedge clk);
      rst = 1'b0; en = 1'b0;
      m_state = '0;
   endtask

   task automatic t_hold();
      term_val = ONES;
      for (int i = 0; i < 7; i++) step(1'b1, "R3 advance");
      for (int i = 0; i < 5; i++) step(1'b0, "R2 hold");
      for (int i = 0; i < 4; i++) step(i[0], "R2 R3 mixed");
   endtask

   task automatic t_free_run();
      logic [W-1:0] first;
      t_reset();
      term_val = ONES;
      first = state;
      for (int i = 0; i < 1022; i++) begin
         step(1'b1, "R4 walk");
         n_chk++;
         if (state == first) begin
            n_bad++;
            $display("FAIL R4: actual %h expected not %h at step %0d", state, first, i);
         end
      end
      step(1'b1, "R4 wrap");
      chk(state, '0, "R4 period 1023");
   endtask

   task automatic t_divide(input int n);
      logic [W-1:0] t;
      int p0;
      t = '0;
      for (int i = 1; i < n; i++) t = nxt(t);
      t_reset();
      term_val = t;
      p0 = n_pulse;
      for (int i = 0; i < 3 * n; i++) step(1'b1, "R6 divide");
      chk(W'(n_pulse - p0), W'(3), "R6 pulse count");
      chk(state, '0, "R6 restart");
   endtask

   task automatic t_gapped();
      logic [W-1:0] t;
      int p0;
      t = nxt(nxt('0));
      t_reset();
      term_val = t;
      p0 = n_pulse;
      for (int i = 0; i < 18; i++) step(i % 3 != 1, "R5 gapped enable");
      chk(W'(n_pulse - p0), W'(4), "R5 gapped pulse count");
   endtask

   initial begin : watchdog
      #(200000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_hold();
      t_free_run();
      t_divide(1);
      t_divide(2);
      t_divide(5);
      t_divide(100);
      t_divide(1023);
      t_gapped();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule